// File: doc/BRIEF.md
# Shift, Logic and Bit-Test Unit

This unit is the non-arithmetic datapath slice of an 8/16-bit processor core. It evaluates one operation per accepted request: a bitwise combine (AND, ORA, EOR), a shift or rotate (ASL, LSR, ROL, ROR), an increment or decrement (INC, DEC), a bit test (BIT), or a test-and-set / test-and-reset of memory bits (TSB, TRB). The operands are the accumulator, a fetched memory operand and the carry-in. A width select picks 8-bit or 16-bit operation. For the shift and step group, a target select picks whether the accumulator or the memory operand is modified.

Each result leaves one clock after the request is accepted. It comes with a write enable for the accumulator or for the memory operand. Each of the N, V, Z and C flags has its own value and its own update enable. A flag whose enable is low carries a value of 0 and must be left untouched by the core. An extra-cycle output tells the sequencer that the operation costs one more internal cycle. Memory access, address generation and instruction fetch sit outside this unit.

Top module: `shlog_unit`

## Requirements
- R1: While rst_ni is low, and immediately on its assertion, valid_o, result_o, all write enables, all flag values, all flag enables and extra_cyc_o are 0.
- R2: A request presented with valid_i high is sampled at a rising clock edge, and its outputs appear after that edge. After any edge at which valid_i was low, every write enable, every flag enable and extra_cyc_o is 0.
- R3: AND (op 0), ORA (op 1) and EOR (op 2) combine the accumulator with the memory operand. The result goes to the accumulator (acc_we_o) regardless of to_mem_i. Only N and Z are updated.
- R4: ASL (op 3) puts the operand MSB into C and shifts left with 0 into bit 0. LSR (op 4) puts bit 0 into C and shifts right with 0 into the MSB. N, Z and C are updated.
- R5: ROL (op 5) moves carry_i into bit 0 and the old MSB into C. ROR (op 6) moves carry_i into the MSB and the old bit 0 into C. N, Z and C are updated.
- R6: INC (op 7) and DEC (op 8) wrap modulo 2^width and update only N and Z.
- R7: BIT (op 9) sets V from memory bit 6 (8-bit) or bit 14 (16-bit), N from the memory MSB, and Z when (memory AND accumulator) is 0. It updates N, V and Z and nothing else, and asserts no write enable.
- R8: TSB (op 10) writes memory OR accumulator, and TRB (op 11) writes memory AND NOT accumulator. Both always target memory. Z is set when (memory AND accumulator) is 0, and only Z is updated.
- R9: For ops 3 to 8, to_mem_i high asserts mem_we_o and to_mem_i low asserts acc_we_o. The two write enables are never high together.
- R10: With wide_i low, only the low byte is computed. Flags use bit 7. The upper byte of result_o equals the upper byte of the written register: the accumulator for ops 0 to 2 and for accumulator-target ops, the memory operand for memory-target ops.
- R11: extra_cyc_o is 1 for ops 3 to 8, 10 and 11, and 0 for ops 0 to 2 and 9.
- R12: Ops 12 to 15 assert no write enable, no flag enable and no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 4 | Operation code (0 to 11 defined) |
| wide_i | input | 1 | 1 = 16-bit, 0 = 8-bit |
| to_mem_i | input | 1 | Shift/step target: 1 = memory operand, 0 = accumulator |
| carry_i | input | 1 | Carry flag in |
| acc_i | input | DATA_W | Accumulator |
| mem_i | input | DATA_W | Memory operand |
| valid_o | output | 1 | Registered request valid |
| result_o | output | DATA_W | Write-back value |
| acc_we_o | output | 1 | Write result to accumulator |
| mem_we_o | output | 1 | Write result to memory operand |
| n_o | output | 1 | Negative flag value |
| v_o | output | 1 | Overflow flag value |
| z_o | output | 1 | Zero flag value |
| c_o | output | 1 | Carry flag value |
| n_we_o | output | 1 | Update N |
| v_we_o | output | 1 | Update V |
| z_we_o | output | 1 | Update Z |
| c_we_o | output | 1 | Update C |
| extra_cyc_o | output | 1 | Operation costs one extra internal cycle |

## Verification
All state is one output register stage, so a wrong decode or datapath value shows at the ports on the cycle right after the request. It can show as a wrong write target, a flag enable raised for a flag the operation must leave alone, or a wrong upper byte in 8-bit mode. A stale enable left over from an earlier request shows as soon as valid_i drops for one cycle. The flag sources that differ from the result (BIT, TSB, TRB) and the carry paths of the rotates are probed with operands whose test value and result value disagree on zero-ness.

// File: rtl/shlog_pkg.sv
package shlog_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_ORA = 4'd1,
    OP_EOR = 4'd2,
    OP_ASL = 4'd3,
    OP_LSR = 4'd4,
    OP_ROL = 4'd5,
    OP_ROR = 4'd6,
    OP_INC = 4'd7,
    OP_DEC = 4'd8,
    OP_BIT = 4'd9,
    OP_TSB = 4'd10,
    OP_TRB = 4'd11
  } shlog_op_e;

  localparam int unsigned FL_N = 3;
  localparam int unsigned FL_V = 2;
  localparam int unsigned FL_Z = 1;
  localparam int unsigned FL_C = 0;

  typedef struct packed {
    logic       acc_we;
    logic       mem_we;
    logic [3:0] flag_we;    // {N,V,Z,C}
    logic       extra;
    logic       from_test;  // Z (and N,V for BIT) from operand test, not result
    logic       pick_logic; // result from bitwise path
  } shlog_ctl_t;

endpackage

// File: rtl/shlog_ctrl.sv
module shlog_ctrl
  import shlog_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic       to_mem_i,
  output shlog_ctl_t ctl_o
);

  always_comb begin
    ctl_o = '0;
    case (op_i)
      OP_AND, OP_ORA, OP_EOR: begin
        ctl_o.acc_we     = 1'b1;
        ctl_o.flag_we    = 4'b1010;
        ctl_o.pick_logic = 1'b1;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        ctl_o.acc_we  = !to_mem_i;
        ctl_o.mem_we  = to_mem_i;
        ctl_o.flag_we = 4'b1011;
        ctl_o.extra   = 1'b1;
      end
      OP_INC, OP_DEC: begin
        ctl_o.acc_we  = !to_mem_i;
        ctl_o.mem_we  = to_mem_i;
        ctl_o.flag_we = 4'b1010;
        ctl_o.extra   = 1'b1;
      end
      OP_BIT: begin
        ctl_o.flag_we    = 4'b1110;
        ctl_o.from_test  = 1'b1;
        ctl_o.pick_logic = 1'b1;
      end
      OP_TSB, OP_TRB: begin
        ctl_o.mem_we     = 1'b1;
        ctl_o.flag_we    = 4'b0010;
        ctl_o.extra      = 1'b1;
        ctl_o.from_test  = 1'b1;
        ctl_o.pick_logic = 1'b1;
      end
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/shlog_shift.sv
module shlog_shift
  import shlog_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] src_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    res_o  = src_i;
    cout_o = 1'b0;
    case (op_i)
      OP_ASL:  {cout_o, res_o} = {src_i, 1'b0};
      OP_LSR:  {res_o, cout_o} = {1'b0, src_i};
      OP_ROL:  {cout_o, res_o} = {src_i, cin_i};
      OP_ROR:  {res_o, cout_o} = {cin_i, src_i};
      OP_INC:  res_o = src_i + ONE;
      OP_DEC:  res_o = src_i - ONE;
      default: res_o = src_i;
    endcase
  end

endmodule

// File: rtl/shlog_logic.sv
module shlog_logic
  import shlog_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned NW = 8
) (
  input  logic [3:0]   op_i,
  input  logic         wide_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mem_i,
  output logic [W-1:0] res_o,
  output logic         tst_z_o,
  output logic         tst_n_o,
  output logic         tst_v_o
);

  localparam int unsigned HW = W - NW;

  logic [W-1:0]  full;
  logic [HW-1:0] keep_hi;
  logic [W-1:0]  overlap;

  always_comb begin
    case (op_i)
      OP_AND:  full = acc_i & mem_i;
      OP_ORA:  full = acc_i | mem_i;
      OP_EOR:  full = acc_i ^ mem_i;
      OP_TSB:  full = mem_i | acc_i;
      OP_TRB:  full = mem_i & ~acc_i;
      default: full = acc_i;
    endcase
    // memory-targeted ops keep the memory's upper byte
    keep_hi = (op_i == OP_TSB || op_i == OP_TRB) ? mem_i[W-1:NW] : acc_i[W-1:NW];
    res_o   = wide_i ? full : {keep_hi, full[NW-1:0]};
  end

  assign overlap = acc_i & mem_i;
  assign tst_z_o = wide_i ? (overlap == '0) : (overlap[NW-1:0] == '0);
  assign tst_n_o = wide_i ? mem_i[W-1] : mem_i[NW-1];
  assign tst_v_o = wide_i ? mem_i[W-2] : mem_i[NW-2];

endmodule

// File: rtl/shlog_unit.sv
module shlog_unit
  import shlog_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              wide_i,
  input  logic              to_mem_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              acc_we_o,
  output logic              mem_we_o,
  output logic              n_o,
  output logic              v_o,
  output logic              z_o,
  output logic              c_o,
  output logic              n_we_o,
  output logic              v_we_o,
  output logic              z_we_o,
  output logic              c_we_o,
  output logic              extra_cyc_o
);

  shlog_ctl_t        ctl;
  logic [DATA_W-1:0] operand;
  logic [NARROW_W-1:0] sn_res;
  logic [DATA_W-1:0] sw_res;
  logic              sn_c, sw_c;
  logic [DATA_W-1:0] shift_res;
  logic              shift_c;
  logic [DATA_W-1:0] lg_res;
  logic              tst_z, tst_n, tst_v;
  logic [DATA_W-1:0] res_d;
  logic              res_n, res_z;
  logic [3:0]        flags_d;

  assign operand = to_mem_i ? mem_i : acc_i;

  shlog_ctrl u_ctrl (
    .op_i     (op_i),
    .to_mem_i (to_mem_i),
    .ctl_o    (ctl)
  );

  shlog_shift #(.W(NARROW_W)) u_shift_n (
    .op_i   (op_i),
    .src_i  (operand[NARROW_W-1:0]),
    .cin_i  (carry_i),
    .res_o  (sn_res),
    .cout_o (sn_c)
  );

  shlog_shift #(.W(DATA_W)) u_shift_w (
    .op_i   (op_i),
    .src_i  (operand),
    .cin_i  (carry_i),
    .res_o  (sw_res),
    .cout_o (sw_c)
  );

  assign shift_res = wide_i ? sw_res : {operand[DATA_W-1:NARROW_W], sn_res};
  assign shift_c   = wide_i ? sw_c : sn_c;

  shlog_logic #(.W(DATA_W), .NW(NARROW_W)) u_logic (
    .op_i    (op_i),
    .wide_i  (wide_i),
    .acc_i   (acc_i),
    .mem_i   (mem_i),
    .res_o   (lg_res),
    .tst_z_o (tst_z),
    .tst_n_o (tst_n),
    .tst_v_o (tst_v)
  );

  assign res_d = ctl.pick_logic ? lg_res : shift_res;
  assign res_n = wide_i ? res_d[DATA_W-1] : res_d[NARROW_W-1];
  assign res_z = wide_i ? (res_d == '0) : (res_d[NARROW_W-1:0] == '0);

  always_comb begin
    flags_d       = '0;
    flags_d[FL_N] = ctl.from_test ? tst_n : res_n;
    flags_d[FL_V] = tst_v;
    flags_d[FL_Z] = ctl.from_test ? tst_z : res_z;
    flags_d[FL_C] = shift_c;
    flags_d       = flags_d & ctl.flag_we;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      result_o    <= '0;
      acc_we_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      {n_o, v_o, z_o, c_o}             <= '0;
      {n_we_o, v_we_o, z_we_o, c_we_o} <= '0;
      extra_cyc_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o    <= res_d;
        acc_we_o    <= ctl.acc_we;
        mem_we_o    <= ctl.mem_we;
        {n_o, v_o, z_o, c_o}             <= flags_d;
        {n_we_o, v_we_o, z_we_o, c_we_o} <= ctl.flag_we;
        extra_cyc_o <= ctl.extra;
      end else begin
        acc_we_o    <= 1'b0;
        mem_we_o    <= 1'b0;
        {n_o, v_o, z_o, c_o}             <= '0;
        {n_we_o, v_we_o, z_we_o, c_we_o} <= '0;
        extra_cyc_o <= 1'b0;
      end
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_we_o && mem_we_o)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !acc_we_o && !mem_we_o && !n_we_o && !v_we_o && !z_we_o && !c_we_o && !extra_cyc_o); // R2

  AST_BIT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_BIT |=> !acc_we_o && !mem_we_o && !c_we_o && v_we_o && n_we_o && z_we_o); // R7

  AST_TEST_Z_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_TSB || op_i == OP_TRB) |=> mem_we_o && z_we_o && !n_we_o && !v_we_o && !c_we_o); // R8

  AST_STEP_NO_CV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_INC || op_i == OP_DEC) |=> !c_we_o && !v_we_o && n_we_o && z_we_o); // R6

  AST_NARROW_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wide_i && (op_i == OP_AND || op_i == OP_ORA || op_i == OP_EOR)
    |=> result_o[DATA_W-1:NARROW_W] == $past(acc_i[DATA_W-1:NARROW_W])); // R10

  AST_ASL_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && wide_i && op_i == OP_ASL |=> c_we_o && c_o == $past(operand[DATA_W-1])); // R4

  AST_EXTRA_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    extra_cyc_o |-> (acc_we_o || mem_we_o)); // R11

endmodule

// File: tb/shlog_unit_tb.sv
`timescale 1ns/1ps
module shlog_unit_tb;

  typedef struct packed {
    logic [3:0]  op;
    logic        wide;
    logic        tomem;
    logic        cin;
    logic [15:0] acc;
    logic [15:0] mem;
    logic [15:0] res;
    logic [1:0]  we;   // {acc,mem}
    logic [3:0]  fl;   // {N,V,Z,C}
    logic [3:0]  fwe;
    logic        x;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b1, 1'b0, 1'b0, 16'hF0F0, 16'h0FF0, 16'h00F0, 2'b10, 4'b0000, 4'b1010, 1'b0},
    '{4'd0,  1'b0, 1'b0, 1'b0, 16'h12F0, 16'hAB0F, 16'h1200, 2'b10, 4'b0010, 4'b1010, 1'b0},
    '{4'd1,  1'b1, 1'b0, 1'b0, 16'h8000, 16'h0001, 16'h8001, 2'b10, 4'b1000, 4'b1010, 1'b0},
    '{4'd2,  1'b0, 1'b0, 1'b0, 16'h34FF, 16'h0080, 16'h347F, 2'b10, 4'b0000, 4'b1010, 1'b0},
    '{4'd3,  1'b1, 1'b0, 1'b0, 16'h8001, 16'h0000, 16'h0002, 2'b10, 4'b0001, 4'b1011, 1'b1},
    '{4'd3,  1'b0, 1'b1, 1'b0, 16'h0000, 16'h5580, 16'h5500, 2'b01, 4'b0011, 4'b1011, 1'b1},
    '{4'd4,  1'b1, 1'b1, 1'b0, 16'h0000, 16'h0003, 16'h0001, 2'b01, 4'b0001, 4'b1011, 1'b1},
    '{4'd4,  1'b0, 1'b0, 1'b0, 16'hFF01, 16'h0000, 16'hFF00, 2'b10, 4'b0011, 4'b1011, 1'b1},
    '{4'd5,  1'b1, 1'b0, 1'b1, 16'h4000, 16'h0000, 16'h8001, 2'b10, 4'b1000, 4'b1011, 1'b1},
    '{4'd5,  1'b0, 1'b1, 1'b1, 16'h0000, 16'h1280, 16'h1201, 2'b01, 4'b0001, 4'b1011, 1'b1},
    '{4'd6,  1'b1, 1'b1, 1'b1, 16'h0000, 16'h0001, 16'h8000, 2'b01, 4'b1001, 4'b1011, 1'b1},
    '{4'd6,  1'b0, 1'b0, 1'b0, 16'hAA01, 16'h0000, 16'hAA00, 2'b10, 4'b0011, 4'b1011, 1'b1},
    '{4'd6,  1'b0, 1'b0, 1'b1, 16'h0002, 16'h0000, 16'h0081, 2'b10, 4'b1000, 4'b1011, 1'b1},
    '{4'd7,  1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 2'b10, 4'b0010, 4'b1010, 1'b1},
    '{4'd7,  1'b0, 1'b1, 1'b0, 16'h0000, 16'h12FF, 16'h1200, 2'b01, 4'b0010, 4'b1010, 1'b1},
    '{4'd8,  1'b0, 1'b0, 1'b0, 16'h3400, 16'h0000, 16'h34FF, 2'b10, 4'b1000, 4'b1010, 1'b1},
    '{4'd8,  1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'hFFFF, 2'b01, 4'b1000, 4'b1010, 1'b1},
    '{4'd9,  1'b1, 1'b0, 1'b0, 16'h00FF, 16'hC000, 16'h0000, 2'b00, 4'b1110, 4'b1110, 1'b0},
    '{4'd9,  1'b0, 1'b0, 1'b0, 16'h0001, 16'h4041, 16'h0000, 2'b00, 4'b0100, 4'b1110, 1'b0},
    '{4'd10, 1'b1, 1'b1, 1'b0, 16'h00F0, 16'h0F0F, 16'h0FFF, 2'b01, 4'b0010, 4'b0010, 1'b1},
    '{4'd11, 1'b0, 1'b1, 1'b0, 16'h0003, 16'hAB07, 16'hAB04, 2'b01, 4'b0000, 4'b0010, 1'b1},
    '{4'd10, 1'b0, 1'b0, 1'b0, 16'h0011, 16'h7700, 16'h7711, 2'b01, 4'b0010, 4'b0010, 1'b1},
    '{4'd0,  1'b1, 1'b1, 1'b0, 16'h00FF, 16'h0F0F, 16'h000F, 2'b10, 4'b0000, 4'b1010, 1'b0},
    '{4'd12, 1'b1, 1'b0, 1'b1, 16'h1234, 16'h5678, 16'h0000, 2'b00, 4'b0000, 4'b0000, 1'b0},
    '{4'd15, 1'b0, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 2'b00, 4'b0000, 4'b0000, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        wide_i = 1'b0;
  logic        to_mem_i = 1'b0;
  logic        carry_i = 1'b0;
  logic [15:0] acc_i = '0;
  logic [15:0] mem_i = '0;
  logic        valid_o;
  logic [15:0] result_o;
  logic        acc_we_o, mem_we_o;
  logic        n_o, v_o, z_o, c_o;
  logic        n_we_o, v_we_o, z_we_o, c_we_o;
  logic        extra_cyc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  shlog_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .wide_i(wide_i), .to_mem_i(to_mem_i), .carry_i(carry_i),
    .acc_i(acc_i), .mem_i(mem_i), .valid_o(valid_o), .result_o(result_o),
    .acc_we_o(acc_we_o), .mem_we_o(mem_we_o),
    .n_o(n_o), .v_o(v_o), .z_o(z_o), .c_o(c_o),
    .n_we_o(n_we_o), .v_we_o(v_we_o), .z_we_o(z_we_o), .c_we_o(c_we_o),
    .extra_cyc_o(extra_cyc_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2: return "R3";
      4'd3, 4'd4:       return "R4";
      4'd5, 4'd6:       return "R5";
      4'd7, 4'd8:       return "R6";
      4'd9:             return "R7";
      4'd10, 4'd11:     return "R8";
      default:          return "R12";
    endcase
  endfunction

  function automatic logic [9:0] all_en();
    return {acc_we_o, mem_we_o, n_we_o, v_we_o, z_we_o, c_we_o,
            extra_cyc_o, n_o | v_o, z_o, c_o};
  endfunction

  task automatic drive(input vec_t v);
    valid_i  = 1'b1;
    op_i     = v.op;
    wide_i   = v.wide;
    to_mem_i = v.tomem;
    carry_i  = v.cin;
    acc_i    = v.acc;
    mem_i    = v.mem;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(valid_o == 1'b0 && result_o == '0, "R1", "reset valid/result",
          {15'd0, valid_o, result_o}, 32'd0);
    check(all_en() == '0, "R1", "reset enables/flags", 32'(all_en()), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(all_en() == '0 && valid_o == 1'b0, "R2", "idle after reset",
          32'(all_en()), 32'd0);

    for (int i = 0; i < NV; i++) begin
      string t;
      drive(VECS[i]);
      @(negedge clk_i);
      t = tag_of(VECS[i].op);
      check(valid_o == 1'b1, "R2", "valid_o", 32'(valid_o), 32'd1);
      check({acc_we_o, mem_we_o} == VECS[i].we, (VECS[i].op inside {[3:8]}) ? "R9" : t,
            "write enables", 32'({acc_we_o, mem_we_o}), 32'(VECS[i].we));
      if (VECS[i].we != 2'b00)
        check(result_o == VECS[i].res, VECS[i].wide ? t : "R10", "result",
              32'(result_o), 32'(VECS[i].res));
      check({n_we_o, v_we_o, z_we_o, c_we_o} == VECS[i].fwe, t, "flag enables",
            32'({n_we_o, v_we_o, z_we_o, c_we_o}), 32'(VECS[i].fwe));
      check(({n_o, v_o, z_o, c_o} & VECS[i].fwe) == VECS[i].fl, t, "flag values",
            32'({n_o, v_o, z_o, c_o} & VECS[i].fwe), 32'(VECS[i].fl));
      check(extra_cyc_o == VECS[i].x, "R11", "extra cycle",
            32'(extra_cyc_o), 32'(VECS[i].x));
    end

    // R2: dropping valid clears enables
    valid_i = 1'b0;
    @(negedge clk_i);
    check(all_en() == '0 && valid_o == 1'b0, "R2", "enables after idle cycle",
          32'(all_en()), 32'd0);

    // R2: outputs do not move before the sampling edge
    drive(VECS[0]);
    #1;
    check(acc_we_o == 1'b0, "R2", "acc_we before edge", 32'(acc_we_o), 32'd0);
    @(negedge clk_i);
    check(acc_we_o == 1'b1 && result_o == 16'h00F0, "R2", "result after edge",
          32'(result_o), 32'h00F0);

    // R1: asynchronous reset mid-stream
    drive(VECS[4]);
    #1;
    rst_ni = 1'b0;
    #0.5;
    check(all_en() == '0 && result_o == '0 && valid_o == 1'b0, "R1",
          "async reset", 32'(all_en()), 32'd0);
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule